// File: doc/BRIEF.md
# Branch Target Buffer with Direction Counters

This block predicts, during instruction fetch, where fetch should go next. It is a set-associative store. Each entry keeps the upper address bits of a branch as a tag, the target that branch jumped to when it was last resolved, a flag that marks it as unconditional, and a 2-bit saturating direction counter. In the same cycle, the lookup port takes the fetch address and returns three things: whether the address is a known branch, whether it is predicted taken, and the predicted next fetch address.

The update port receives branches that execute has resolved. Each carries its address, its actual direction, its actual target and whether it is unconditional. If the branch is already present, its entry is refreshed. If it is not present, an entry is created. A fetch that misses gives no entry. When a set is full, the entry to evict comes from a per-set tree pseudo-LRU. Any update, whether it refreshes or allocates, marks that way as most recently used.

Top module: `btb_pred`

## Requirements
- R1: After reset, every entry is invalid. Every lookup then reports no hit and not taken, and the predicted next address is the fetch address plus 4.
- R2: The set is selected by address bits [7:2], and bits [31:8] form the tag. A lookup hits only when a valid entry in that set holds the same tag.
- R3: On a hit to a conditional entry, the prediction is taken when the counter is 2 or 3, and the next address is the stored target. When the counter is 0 or 1, the prediction is not taken and the next address is the fetch address plus 4.
- R4: On a hit to an entry flagged unconditional, the prediction is taken and the next address is the stored target, whatever the counter holds.
- R5: An update that hits an existing entry does three things. It raises the counter by one if the branch was taken, or lowers it by one if not, saturating at 0 and 3. It replaces the target with the resolved target. It replaces the unconditional flag with the resolved flag.
- R6: An update that misses creates an entry holding the resolved tag, target and flag. Its counter starts at 2 if the branch was taken and at 1 if it was not.
- R7: A new entry goes into the lowest-numbered invalid way of its set. When no way is invalid, it goes into the pseudo-LRU victim.
- R8: Each set has a 3-bit tree: node 1 is the root, and nodes 2 and 3 cover ways 0–1 and 2–3. A node bit of 0 points left, toward the lower ways. The victim is found by following the bits from the root. Each update, hit or allocation, sets every node on the path to the written way so that it points away from that way. All bits reset to 0.
- R9: When a lookup and an update fall in the same cycle, the lookup returns the contents as they were before that update.
- R10: While the update valid input is low, the stored contents do not change, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | 32 | Fetch address to look up |
| lk_hit | output | 1 | Lookup found a valid matching entry |
| lk_taken | output | 1 | Predicted taken |
| lk_next | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch |
| upd_target | input | 32 | Actual target of the resolved branch |
| upd_uncond | input | 1 | Resolved branch is unconditional |

## Verification
The hardest state to reach is a full set where the pseudo-LRU tree has been skewed by a mix of refreshes and allocations. Only in that state does the victim choice differ from simple fill order. The stimulus drives a long deterministic stream of resolved branches into three sets, drawing from six tags per set so that evictions keep recurring. After every step, the bench looks up all eighteen addresses and compares the result against an arithmetic model of the counters and tree bits. Directed sequences then walk one counter across both saturation limits, and a same-cycle lookup and update exercise the read-before-write ordering.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_STRONG_NT = 2'b00;
  localparam ctr_t CTR_WEAK_NT   = 2'b01;
  localparam ctr_t CTR_WEAK_T    = 2'b10;
  localparam ctr_t CTR_STRONG_T  = 2'b11;

  // Saturating step toward the resolved direction.
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t res;
    if (taken) res = (cur == CTR_STRONG_T)  ? cur : cur + 2'd1;
    else       res = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
    return res;
  endfunction

  // Starting value for a freshly created entry.
  function automatic ctr_t ctr_seed(input logic taken);
    return taken ? CTR_WEAK_T : CTR_WEAK_NT;
  endfunction

endpackage

// File: rtl/btb_way.sv
module btb_way
  import btb_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int IDX_W = 6,
  parameter int TAG_W = 24,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  // lookup read port
  input  logic [IDX_W-1:0] ra_idx,
  output logic             ra_vld,
  output logic [TAG_W-1:0] ra_tag,
  output logic [PC_W-1:0]  ra_tgt,
  output logic             ra_dir,
  output logic             ra_unc,
  // update read port
  input  logic [IDX_W-1:0] rb_idx,
  output logic             rb_vld,
  output logic [TAG_W-1:0] rb_tag,
  output ctr_t             rb_ctr,
  // write port
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_tgt,
  input  ctr_t             wr_ctr,
  input  logic             wr_unc,
  output logic [SETS-1:0]  vld_vec
);

  logic [SETS-1:0]  vld_q;
  logic [SETS-1:0]  vld_d;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [PC_W-1:0]  tgt_q [SETS];
  ctr_t             ctr_q [SETS];
  logic [SETS-1:0]  unc_q;

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // Payload arrays carry no reset; the valid bit guards them.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= wr_tgt;
      ctr_q[wr_idx] <= wr_ctr;
      unc_q[wr_idx] <= wr_unc;
    end
  end

  assign ra_vld  = vld_q[ra_idx];
  assign ra_tag  = tag_q[ra_idx];
  assign ra_tgt  = tgt_q[ra_idx];
  assign ra_dir  = ctr_q[ra_idx][1];
  assign ra_unc  = unc_q[ra_idx];

  assign rb_vld  = vld_q[rb_idx];
  assign rb_tag  = tag_q[rb_idx];
  assign rb_ctr  = ctr_q[rb_idx];

  assign vld_vec = vld_q;

endmodule

// File: rtl/btb_plru.sv
module btb_plru #(
  parameter int SETS  = 64,
  parameter int IDX_W = 6,
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic [WAY_W-1:0] victim,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way
);

  typedef logic [WAYS-1:1] tree_t;

  tree_t tree_q [SETS];
  tree_t tree_cur;
  tree_t tree_nxt;

  function automatic logic [WAY_W-1:0] tree_pick(input tree_t t);
    int node;
    node = 1;
    for (int l = 0; l < WAY_W; l++) node = node * 2 + int'(t[node]);
    return WAY_W'(node - WAYS);
  endfunction

  function automatic tree_t tree_touch(input tree_t t, input logic [WAY_W-1:0] w);
    tree_t res;
    int    node;
    logic  dir;
    res  = t;
    node = 1;
    for (int l = 0; l < WAY_W; l++) begin
      dir       = w[WAY_W-1-l];
      res[node] = ~dir;
      node      = node * 2 + int'(dir);
    end
    return res;
  endfunction

  assign tree_cur = tree_q[idx];
  assign victim   = tree_pick(tree_cur);

  always_comb begin
    tree_nxt = tree_cur;
    if (touch_en) tree_nxt = tree_touch(tree_cur, touch_way);
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              tree_q[s] <= '0;
      else if (touch_en && idx == IDX_W'(s))   tree_q[s] <= tree_nxt;
    end
  end

endmodule

// File: rtl/btb_alloc.sv
module btb_alloc
  import btb_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]  way_vld,
  input  logic [WAYS-1:0]  way_hit,
  input  ctr_t             hit_ctr,
  input  logic [WAY_W-1:0] victim,
  input  logic             taken,
  output logic             is_hit,
  output logic [WAY_W-1:0] dst_way,
  output ctr_t             dst_ctr
);

  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] free_way;
  logic             any_free;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (way_hit[w]) hit_way = WAY_W'(w);
  end

  // Descending scan leaves the lowest free way selected.
  always_comb begin
    free_way = '0;
    any_free = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_vld[w]) begin
        free_way = WAY_W'(w);
        any_free = 1'b1;
      end
    end
  end

  assign is_hit  = |way_hit;
  assign dst_way = is_hit ? hit_way : (any_free ? free_way : victim);
  assign dst_ctr = is_hit ? ctr_step(hit_ctr, taken) : ctr_seed(taken);

endmodule

// File: rtl/btb_pred.sv
module btb_pred
  import btb_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int SETS        = 64,
  parameter int WAYS        = 4,
  parameter int INSTR_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic            lk_taken,
  output logic [PC_W-1:0] lk_next,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_uncond
);

  localparam int OFS_W = $clog2(INSTR_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = PC_W - IDX_W - OFS_W;
  localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;

  assign lk_idx = lk_pc[OFS_W +: IDX_W];
  assign lk_tag = lk_pc[PC_W-1 -: TAG_W];
  assign up_idx = upd_pc[OFS_W +: IDX_W];
  assign up_tag = upd_pc[PC_W-1 -: TAG_W];

  logic             unused_ofs;
  assign unused_ofs = ^{lk_pc[OFS_W-1:0], upd_pc[OFS_W-1:0]};

  // Per-way read data
  logic             a_vld [WAYS];
  logic [TAG_W-1:0] a_tag [WAYS];
  logic [PC_W-1:0]  a_tgt [WAYS];
  logic             a_dir [WAYS];
  logic             a_unc [WAYS];
  logic             b_vld [WAYS];
  logic [TAG_W-1:0] b_tag [WAYS];
  ctr_t             b_ctr [WAYS];
  logic [SETS-1:0]  w_vld_vec [WAYS];

  logic [WAYS-1:0]      way_we;
  logic [WAYS*SETS-1:0] vld_flat;
  ctr_t                 wr_ctr;
  logic [WAY_W-1:0]     wr_way;
  logic [WAY_W-1:0]     victim;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    btb_way #(
      .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)
    ) u_way (
      .clk    (clk),
      .rst_n  (rst_n),
      .ra_idx (lk_idx),
      .ra_vld (a_vld[w]),
      .ra_tag (a_tag[w]),
      .ra_tgt (a_tgt[w]),
      .ra_dir (a_dir[w]),
      .ra_unc (a_unc[w]),
      .rb_idx (up_idx),
      .rb_vld (b_vld[w]),
      .rb_tag (b_tag[w]),
      .rb_ctr (b_ctr[w]),
      .wr_en  (way_we[w]),
      .wr_idx (up_idx),
      .wr_tag (up_tag),
      .wr_tgt (upd_target),
      .wr_ctr (wr_ctr),
      .wr_unc (upd_uncond),
      .vld_vec(w_vld_vec[w])
    );
    assign vld_flat[w*SETS +: SETS] = w_vld_vec[w];
    assign way_we[w] = upd_valid && (wr_way == WAY_W'(w));
  end

  // Lookup path: tag compare and one-hot select
  logic [WAYS-1:0] lk_hitv;
  logic [PC_W-1:0] lk_sel_tgt;
  logic            lk_sel_dir;
  logic            lk_sel_unc;

  always_comb begin
    lk_hitv    = '0;
    lk_sel_tgt = '0;
    lk_sel_dir = 1'b0;
    lk_sel_unc = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      lk_hitv[w] = a_vld[w] && (a_tag[w] == lk_tag);
      if (lk_hitv[w]) begin
        lk_sel_tgt = lk_sel_tgt | a_tgt[w];
        lk_sel_dir = lk_sel_dir | a_dir[w];
        lk_sel_unc = lk_sel_unc | a_unc[w];
      end
    end
  end

  assign lk_hit   = |lk_hitv;
  assign lk_taken = lk_hit && (lk_sel_unc || lk_sel_dir);
  assign lk_next  = lk_taken ? lk_sel_tgt : lk_pc + STEP;

  // Update path: tag compare and counter of the matching way
  logic [WAYS-1:0] up_hitv;
  logic [WAYS-1:0] up_vldv;
  ctr_t            up_hit_ctr;
  logic            up_is_hit;

  always_comb begin
    up_hitv    = '0;
    up_vldv    = '0;
    up_hit_ctr = '0;
    for (int w = 0; w < WAYS; w++) begin
      up_vldv[w] = b_vld[w];
      up_hitv[w] = b_vld[w] && (b_tag[w] == up_tag);
      if (up_hitv[w]) up_hit_ctr = up_hit_ctr | b_ctr[w];
    end
  end

  btb_alloc #(.WAYS(WAYS), .WAY_W(WAY_W)) u_alloc (
    .way_vld(up_vldv),
    .way_hit(up_hitv),
    .hit_ctr(up_hit_ctr),
    .victim (victim),
    .taken  (upd_taken),
    .is_hit (up_is_hit),
    .dst_way(wr_way),
    .dst_ctr(wr_ctr)
  );

  btb_plru #(.SETS(SETS), .IDX_W(IDX_W), .WAYS(WAYS), .WAY_W(WAY_W)) u_plru (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx      (up_idx),
    .victim   (victim),
    .touch_en (upd_valid),
    .touch_way(wr_way)
  );

  logic unused_hit;
  assign unused_hit = up_is_hit;

endmodule

// File: rtl/btb_pred_chk.sv
module btb_pred_chk #(
  parameter int PC_W  = 32,
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int INSTR_BYTES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [PC_W-1:0]      lk_pc,
  input logic                 lk_hit,
  input logic                 lk_taken,
  input logic [PC_W-1:0]      lk_next,
  input logic                 lk_sel_unc,
  input logic                 upd_valid,
  input logic [WAYS-1:0]      way_we,
  input logic [WAYS*SETS-1:0] vld_flat
);

  localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

  AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (!lk_taken && lk_next == lk_pc + STEP)); // R1

  AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_taken |-> lk_hit); // R3

  AST_UNCOND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_sel_unc) |-> lk_taken); // R4

  AST_ONE_WAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_we)); // R7

  AST_WRITE_NEEDS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    (way_we != '0) |-> upd_valid); // R10

  AST_IDLE_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(vld_flat)); // R10

endmodule

bind btb_pred btb_pred_chk #(
  .PC_W(PC_W), .SETS(SETS), .WAYS(WAYS), .INSTR_BYTES(INSTR_BYTES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_pc     (lk_pc),
  .lk_hit    (lk_hit),
  .lk_taken  (lk_taken),
  .lk_next   (lk_next),
  .lk_sel_unc(lk_sel_unc),
  .upd_valid (upd_valid),
  .way_we    (way_we),
  .vld_flat  (vld_flat)
);

// File: tb/btb_pred_bench.sv
module btb_pred_bench;

  localparam int NS = 64;
  localparam int NW = 4;

  logic        clk;
  logic        rst_n;
  logic [31:0] lk_pc;
  logic        lk_hit, lk_taken;
  logic [31:0] lk_next;
  logic        upd_valid, upd_taken, upd_uncond;
  logic [31:0] upd_pc, upd_target;

  int n_chk;
  int n_bad;

  btb_pred u_btb_pred (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_next(lk_next),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .upd_uncond(upd_uncond)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Reference state
  logic        m_vld [NS][NW];
  logic [23:0] m_tag [NS][NW];
  logic [31:0] m_tgt [NS][NW];
  logic [1:0]  m_ctr [NS][NW];
  logic        m_unc [NS][NW];
  logic [3:1]  m_tree [NS];

  task automatic m_clear();
    for (int s = 0; s < NS; s++) begin
      m_tree[s] = '0;
      for (int w = 0; w < NW; w++) m_vld[s][w] = 1'b0;
    end
  endtask

  task automatic m_look(input logic [31:0] pc, output logic h, output logic tk,
                        output logic [31:0] nx);
    int s;
    s  = int'(pc[7:2]);
    h  = 1'b0;
    tk = 1'b0;
    nx = pc + 32'd4;
    for (int w = 0; w < NW; w++) begin
      if (m_vld[s][w] && m_tag[s][w] == pc[31:8]) begin
        h  = 1'b1;
        tk = m_unc[s][w] || (m_ctr[s][w] >= 2'd2);
        if (tk) nx = m_tgt[s][w];
      end
    end
  endtask

  task automatic m_upd(input logic [31:0] pc, input logic tk, input logic [31:0] tg,
                       input logic un);
    int s, way, node, b;
    s   = int'(pc[7:2]);
    way = -1;
    for (int w = 0; w < NW; w++)
      if (m_vld[s][w] && m_tag[s][w] == pc[31:8]) way = w;
    if (way >= 0) begin
      if (tk && m_ctr[s][way] != 2'd3) m_ctr[s][way] = m_ctr[s][way] + 2'd1;
      if (!tk && m_ctr[s][way] != 2'd0) m_ctr[s][way] = m_ctr[s][way] - 2'd1;
    end else begin
      for (int w = NW - 1; w >= 0; w--) if (!m_vld[s][w]) way = w;
      if (way < 0) begin
        node = 1;
        for (int l = 0; l < 2; l++) node = node * 2 + int'(m_tree[s][node]);
        way = node - NW;
      end
      m_vld[s][way] = 1'b1;
      m_tag[s][way] = pc[31:8];
      m_ctr[s][way] = tk ? 2'd2 : 2'd1;
    end
    m_tgt[s][way] = tg;
    m_unc[s][way] = un;
    node = 1;
    for (int l = 0; l < 2; l++) begin
      b = (way >> (1 - l)) & 1;
      m_tree[s][node] = (b == 0);
      node = node * 2 + b;
    end
  endtask

  task automatic chk_now(input string rq);
    logic eh, et;
    logic [31:0] en;
    m_look(lk_pc, eh, et, en);
    n_chk++;
    if (lk_hit !== eh || lk_taken !== et || lk_next !== en) begin
      n_bad++;
      $display("FAIL %s pc=%h actual hit=%0b taken=%0b next=%h expected hit=%0b taken=%0b next=%h",
               rq, lk_pc, lk_hit, lk_taken, lk_next, eh, et, en);
    end
  endtask

  task automatic chk_lk(input logic [31:0] pc, input string rq);
    @(negedge clk);
    lk_pc = pc;
    #1;
    chk_now(rq);
  endtask

  task automatic do_upd(input logic [31:0] pc, input logic tk, input logic [31:0] tg,
                        input logic un);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tg; upd_uncond = un;
    @(posedge clk);
    #1;
    upd_valid = 1'b0;
    m_upd(pc, tk, tg, un);
  endtask

  // Junk on the update fields with valid low: nothing may change (R10)
  task automatic idle_upd(input logic [31:0] pc);
    @(negedge clk);
    upd_valid = 1'b0; upd_pc = pc; upd_taken = 1'b1; upd_target = 32'hDEAD_BEE0; upd_uncond = 1'b1;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] mk_pc(input int tag, input int set);
    return {24'h5A_0000 + 24'(tag * 19), 6'(set), 2'b00};
  endfunction

  logic done;

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int sets3 [3];
    logic [31:0] p;
    sets3[0] = 3; sets3[1] = 17; sets3[2] = 63;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; lk_pc = '0;
    upd_valid = 1'b0; upd_pc = '0; upd_taken = 1'b0; upd_target = '0; upd_uncond = 1'b0;
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: everything misses after reset, in every set
    for (int s = 0; s < NS; s++) chk_lk(mk_pc(s % 6, s), "R1");

    // R6: first resolution creates the entry with a weak counter
    do_upd(mk_pc(0, 40), 1'b0, 32'h0000_1000, 1'b0);
    chk_lk(mk_pc(0, 40), "R6 new not-taken");
    do_upd(mk_pc(1, 40), 1'b1, 32'h0000_2000, 1'b0);
    chk_lk(mk_pc(1, 40), "R6 new taken");
    // R2: same set, different tag misses; same tag, other set misses
    chk_lk(mk_pc(2, 40), "R2 tag mismatch");
    chk_lk(mk_pc(1, 41), "R2 set mismatch");

    // R5 / R3: walk a counter to both limits
    for (int k = 0; k < 4; k++) begin
      do_upd(mk_pc(1, 40), 1'b1, 32'h0000_2000 + 32'(k * 16), 1'b0);
      chk_lk(mk_pc(1, 40), "R5 saturate up");
    end
    do_upd(mk_pc(1, 40), 1'b0, 32'h0000_3000, 1'b0);
    chk_lk(mk_pc(1, 40), "R5 one step down still taken");
    for (int k = 0; k < 5; k++) begin
      do_upd(mk_pc(1, 40), 1'b0, 32'h0000_3000, 1'b0);
      chk_lk(mk_pc(1, 40), "R5 saturate down");
    end
    do_upd(mk_pc(1, 40), 1'b1, 32'h0000_4000, 1'b0);
    chk_lk(mk_pc(1, 40), "R3 counter 1 predicts not taken");

    // R4: unconditional flag overrides a low counter
    do_upd(mk_pc(0, 40), 1'b0, 32'h0000_5000, 1'b1);
    chk_lk(mk_pc(0, 40), "R4 unconditional");

    // R9: same-cycle lookup sees the old contents
    p = mk_pc(3, 40);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = p; upd_taken = 1'b1; upd_target = 32'h0000_6000; upd_uncond = 1'b0;
    lk_pc = p;
    #1;
    chk_now("R9 old contents");
    @(posedge clk);
    #1;
    upd_valid = 1'b0;
    m_upd(p, 1'b1, 32'h0000_6000, 1'b0);
    chk_lk(p, "R9 new contents after edge");

    // R10: ignored update does not allocate or modify
    idle_upd(mk_pc(4, 40));
    chk_lk(mk_pc(4, 40), "R10 no allocation");
    idle_upd(mk_pc(1, 40));
    chk_lk(mk_pc(1, 40), "R10 no modification");

    // R7 / R8 / R5: long stream with evictions in three sets
    for (int i = 0; i < 150; i++) begin
      int s, t;
      s = sets3[i % 3];
      t = (i * 5 + i / 7) % 6;
      if (i % 11 == 10) idle_upd(mk_pc(t, s));
      else do_upd(mk_pc(t, s), ((i * 3) % 7) < 4, 32'h0040_0000 + 32'(i * 36), t == 5);
      for (int ss = 0; ss < 3; ss++)
        for (int tt = 0; tt < 6; tt++)
          chk_lk(mk_pc(tt, sets3[ss]), "R7/R8 replacement sweep");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule